// File: doc/BRIEF.md
# LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel: a pixel clock enable, horizontal and vertical sync, a data-enable strobe, and the current pixel and line positions within the full frame. Each line and each frame runs through four segments in a fixed order: sync pulse, back porch, active region, front porch. The length of every segment is programmed through input ports. Each length is written as the wanted count minus one, so a value of zero gives a one-unit segment.

A clock divider derives the pixel rate from the block clock. When a direction bit is clear, the divider is bypassed and a pixel advances on every clock. When the bit is set, a pixel advances once every divider-field-plus-one clocks. Each sync output has a polarity input.

A frame interrupt status bit is set when the vertical sync of a new frame begins, if the interrupt is enabled. Software clears the bit by pulsing a write-one-to-clear input. Register access is out of scope here, so every setting arrives as a plain input.

Top module: `lcd_timing_gen`

## Requirements
- R1: Each line lasts (hsw_m1+1)+(hbp_m1+1)+(width_m1+1)+(hfp_m1+1) pixel ticks, in the order sync, back porch, active, front porch. `h_pos` counts 0 upward within the line and returns to 0 after the last front-porch pixel.
- R2: The vertical axis uses the same segment order, measured in lines. `v_pos` advances only on the pixel tick that ends a line, and it returns to 0 after the last front-porch line.
- R3: A frame spans the horizontal total multiplied by the vertical total in pixel ticks. After that many ticks from reset, both `h_pos` and `v_pos` read 0 again.
- R4: `de` is 1 exactly when the horizontal axis and the vertical axis are both in their active segments.
- R5: A sync output is at level 1 during its sync segment when its polarity input is 0. When the polarity input is 1, the output is inverted.
- R6: While `cfg_div_en` is 0, `pix_ce` is 1 on every clock, whatever value `cfg_div_m1` holds.
- R7: While `cfg_div_en` is 1, `pix_ce` pulses once every `cfg_div_m1`+1 clocks, which allows divisors up to 256. Between pulses, the positions and the sync and enable outputs hold their values.
- R8: When `irq_en` is 1, `irq_pending` is set on the clock edge at which a new frame enters vertical sync. The frame that starts at reset release does not set it.
- R9: When `irq_en` is 0, the start of a frame leaves `irq_pending` unchanged at 0.
- R10: A one-clock pulse on `irq_clr` clears `irq_pending`. If a set and a clear fall on the same edge, the set wins.
- R11: In reset, both positions are 0, both axes are in their sync segment, `de` is 0 and `irq_pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_hsw_m1 | input | FIELD_W | Horizontal sync width minus one, in pixels |
| cfg_hbp_m1 | input | FIELD_W | Horizontal back porch minus one |
| cfg_hfp_m1 | input | FIELD_W | Horizontal front porch minus one |
| cfg_width_m1 | input | SIZE_W | Active pixels per line minus one |
| cfg_vsw_m1 | input | FIELD_W | Vertical sync width minus one, in lines |
| cfg_vbp_m1 | input | FIELD_W | Vertical back porch minus one |
| cfg_vfp_m1 | input | FIELD_W | Vertical front porch minus one |
| cfg_height_m1 | input | SIZE_W | Active lines per frame minus one |
| cfg_div_m1 | input | DIV_W | Pixel clock divisor minus one |
| cfg_div_en | input | 1 | 1 selects the divided pixel clock, 0 selects one pixel per clock |
| cfg_hs_pol | input | 1 | 1 inverts hsync |
| cfg_vs_pol | input | 1 | 1 inverts vsync |
| irq_en | input | 1 | Frame interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| h_pos | output | POS_W | Pixel position within the line |
| v_pos | output | POS_W | Line position within the frame |
| irq_pending | output | 1 | Frame interrupt status |

## Verification
The bench uses the default parameters: FIELD_W=8, SIZE_W=11 and DIV_W=8, which give POS_W=13. It programs small segment lengths, down to the one-unit minimum, so that complete frames and several frame wraps happen within a few hundred clocks. The 8-bit divider field lets the bench program a divisor of 255 and measure the gap between pixel enables directly. Frame-start interrupts, clears and a coinciding set and clear are driven at known pixel counts.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

   typedef enum logic [1:0] {
      PH_SYNC   = 2'd0,
      PH_BACK   = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_FRONT  = 2'd3
   } tg_phase_e;

   function automatic tg_phase_e tg_next_phase(input tg_phase_e cur);
      tg_phase_e nxt;
      case (cur)
         PH_SYNC:   nxt = PH_BACK;
         PH_BACK:   nxt = PH_ACTIVE;
         PH_ACTIVE: nxt = PH_FRONT;
         default:   nxt = PH_SYNC;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/tg_pix_div.sv
module tg_pix_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_en,
   input  logic [DIV_W-1:0] div_m1,
   output logic             pix_ce
);

   logic [DIV_W-1:0] cnt_q;
   logic             hit;

   assign hit    = (cnt_q == div_m1);
   assign pix_ce = ~div_en | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (pix_ce) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/tg_axis_counter.sv
module tg_axis_counter
   import lcd_tg_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int SIZE_W  = 11,
   parameter int POS_W   = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic [FIELD_W-1:0] sync_m1,
   input  logic [FIELD_W-1:0] back_m1,
   input  logic [SIZE_W-1:0]  act_m1,
   input  logic [FIELD_W-1:0] front_m1,
   output logic               in_sync,
   output logic               in_active,
   output logic               wrap,
   output logic [POS_W-1:0]   pos
);

   localparam int CW = (FIELD_W > SIZE_W) ? FIELD_W : SIZE_W;

   tg_phase_e         phase_q;
   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     seg_last;
   logic              seg_done;
   logic [POS_W-1:0]  pos_q;

   always_comb begin
      seg_last = CW'(front_m1);
      case (phase_q)
         PH_SYNC:   seg_last = CW'(sync_m1);
         PH_BACK:   seg_last = CW'(back_m1);
         PH_ACTIVE: seg_last = CW'(act_m1);
         default:   seg_last = CW'(front_m1);
      endcase
   end

   assign seg_done  = (cnt_q == seg_last);
   assign wrap      = step && seg_done && (phase_q == PH_FRONT);
   assign in_sync   = (phase_q == PH_SYNC);
   assign in_active = (phase_q == PH_ACTIVE);
   assign pos       = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SYNC;
         cnt_q   <= '0;
         pos_q   <= '0;
      end else if (step) begin
         if (seg_done) begin
            cnt_q   <= '0;
            phase_q <= tg_next_phase(phase_q);
         end else begin
            cnt_q   <= cnt_q + CW'(1);
         end
         pos_q <= wrap ? '0 : pos_q + POS_W'(1);
      end
   end

endmodule

// File: rtl/tg_frame_irq.sv
module tg_frame_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   input  logic irq_en,
   input  logic irq_clr,
   output logic status
);

   logic status_q;
   logic set_now;

   assign set_now = frame_start & irq_en;
   assign status  = status_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= 1'b0;
      end else if (set_now) begin
         status_q <= 1'b1;
      end else if (irq_clr) begin
         status_q <= 1'b0;
      end
   end

endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
   import lcd_tg_pkg::*;
#(
   parameter int FIELD_W = 8,
   parameter int SIZE_W  = 11,
   parameter int DIV_W   = 8,
   localparam int POS_W  = ((FIELD_W > SIZE_W) ? FIELD_W : SIZE_W) + 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] cfg_hsw_m1,
   input  logic [FIELD_W-1:0] cfg_hbp_m1,
   input  logic [FIELD_W-1:0] cfg_hfp_m1,
   input  logic [SIZE_W-1:0]  cfg_width_m1,
   input  logic [FIELD_W-1:0] cfg_vsw_m1,
   input  logic [FIELD_W-1:0] cfg_vbp_m1,
   input  logic [FIELD_W-1:0] cfg_vfp_m1,
   input  logic [SIZE_W-1:0]  cfg_height_m1,
   input  logic [DIV_W-1:0]   cfg_div_m1,
   input  logic               cfg_div_en,
   input  logic               cfg_hs_pol,
   input  logic               cfg_vs_pol,
   input  logic               irq_en,
   input  logic               irq_clr,
   output logic               pix_ce,
   output logic               hsync,
   output logic               vsync,
   output logic               de,
   output logic [POS_W-1:0]   h_pos,
   output logic [POS_W-1:0]   v_pos,
   output logic               irq_pending
);

   localparam int N_AXES = 2;

   initial begin
      assert (FIELD_W >= 1) else $error("FIELD_W must be at least 1");
      assert (SIZE_W >= 1)  else $error("SIZE_W must be at least 1");
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("DIV_W out of range");
   end

   logic ce;
   logic h_sync_seg, h_act_seg, h_wrap;
   logic v_sync_seg, v_act_seg, v_wrap;
   logic v_step;

   tg_pix_div #(.DIV_W(DIV_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .div_en (cfg_div_en),
      .div_m1 (cfg_div_m1),
      .pix_ce (ce)
   );

   tg_axis_counter #(.FIELD_W(FIELD_W), .SIZE_W(SIZE_W), .POS_W(POS_W)) u_haxis (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (ce),
      .sync_m1   (cfg_hsw_m1),
      .back_m1   (cfg_hbp_m1),
      .act_m1    (cfg_width_m1),
      .front_m1  (cfg_hfp_m1),
      .in_sync   (h_sync_seg),
      .in_active (h_act_seg),
      .wrap      (h_wrap),
      .pos       (h_pos)
   );

   assign v_step = ce & h_wrap;

   tg_axis_counter #(.FIELD_W(FIELD_W), .SIZE_W(SIZE_W), .POS_W(POS_W)) u_vaxis (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (v_step),
      .sync_m1   (cfg_vsw_m1),
      .back_m1   (cfg_vbp_m1),
      .act_m1    (cfg_height_m1),
      .front_m1  (cfg_vfp_m1),
      .in_sync   (v_sync_seg),
      .in_active (v_act_seg),
      .wrap      (v_wrap),
      .pos       (v_pos)
   );

   tg_frame_irq u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (v_wrap),
      .irq_en      (irq_en),
      .irq_clr     (irq_clr),
      .status      (irq_pending)
   );

   logic [N_AXES-1:0] sync_seg;
   logic [N_AXES-1:0] sync_inv;
   logic [N_AXES-1:0] sync_out;

   assign sync_seg = {v_sync_seg, h_sync_seg};
   assign sync_inv = {cfg_vs_pol, cfg_hs_pol};

   for (genvar g = 0; g < N_AXES; g++) begin : g_pol
      assign sync_out[g] = sync_seg[g] ^ sync_inv[g];
   end

   assign hsync  = sync_out[0];
   assign vsync  = sync_out[1];
   assign de     = h_act_seg & v_act_seg;
   assign pix_ce = ce;

endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk #(
   parameter int POS_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_div_en,
   input logic             cfg_hs_pol,
   input logic             cfg_vs_pol,
   input logic             irq_en,
   input logic             irq_clr,
   input logic             pix_ce,
   input logic             hsync,
   input logic             vsync,
   input logic             de,
   input logic [POS_W-1:0] h_pos,
   input logic [POS_W-1:0] v_pos,
   input logic             irq_pending
);

   // R7: outputs hold between pixel enables
   a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_ce |=> ($stable(h_pos) && $stable(v_pos) && $stable(hsync) && $stable(vsync) && $stable(de)));

   // R6: undivided clock gives an enable every cycle
   a_r6_undivided: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_div_en |-> pix_ce);

   // R1: pixel position steps by one or wraps to zero
   a_r1_hpos_step: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ce |=> ((h_pos == $past(h_pos) + POS_W'(1)) || (h_pos == '0)));

   // R2: line position only moves when the line wraps
   a_r2_vpos_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(v_pos) |-> (h_pos == '0));

   // R4: data enable never overlaps a sync pulse
   a_r4_de_outside_sync: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> (!(hsync ^ cfg_hs_pol) && !(vsync ^ cfg_vs_pol)));

   // R8: status rises only at frame start while enabled
   a_r8_set_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pending) |-> (h_pos == '0 && v_pos == '0 && $past(irq_en)));

   // R10: status falls only after a clear pulse
   a_r10_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_pending) |-> $past(irq_clr));

endmodule

bind lcd_timing_gen lcd_timing_gen_chk #(.POS_W(POS_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_div_en  (cfg_div_en),
   .cfg_hs_pol  (cfg_hs_pol),
   .cfg_vs_pol  (cfg_vs_pol),
   .irq_en      (irq_en),
   .irq_clr     (irq_clr),
   .pix_ce      (pix_ce),
   .hsync       (hsync),
   .vsync       (vsync),
   .de          (de),
   .h_pos       (h_pos),
   .v_pos       (v_pos),
   .irq_pending (irq_pending)
);

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;

   localparam int FW = 8;
   localparam int SW = 11;
   localparam int DW = 8;
   localparam int PW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [FW-1:0] cfg_hsw_m1 = '0, cfg_hbp_m1 = '0, cfg_hfp_m1 = '0;
   logic [FW-1:0] cfg_vsw_m1 = '0, cfg_vbp_m1 = '0, cfg_vfp_m1 = '0;
   logic [SW-1:0] cfg_width_m1 = '0, cfg_height_m1 = '0;
   logic [DW-1:0] cfg_div_m1 = '0;
   logic          cfg_div_en = 1'b0, cfg_hs_pol = 1'b0, cfg_vs_pol = 1'b0;
   logic          irq_en = 1'b0, irq_clr = 1'b0;
   logic          pix_ce, hsync, vsync, de, irq_pending;
   logic [PW-1:0] h_pos, v_pos;

   always #4 clk = ~clk;

   lcd_timing_gen #(.FIELD_W(FW), .SIZE_W(SW), .DIV_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_hsw_m1(cfg_hsw_m1), .cfg_hbp_m1(cfg_hbp_m1), .cfg_hfp_m1(cfg_hfp_m1),
      .cfg_width_m1(cfg_width_m1),
      .cfg_vsw_m1(cfg_vsw_m1), .cfg_vbp_m1(cfg_vbp_m1), .cfg_vfp_m1(cfg_vfp_m1),
      .cfg_height_m1(cfg_height_m1),
      .cfg_div_m1(cfg_div_m1), .cfg_div_en(cfg_div_en),
      .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
      .irq_en(irq_en), .irq_clr(irq_clr),
      .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
      .h_pos(h_pos), .v_pos(v_pos), .irq_pending(irq_pending)
   );

   typedef struct {
      bit hs;
      bit vs;
      bit de;
      int h;
      int v;
   } px_t;

   px_t exp_q[$];
   int  n_chk = 0;
   int  n_bad = 0;
   int  exp_gap = 1;
   int  hsw, hbp, wid, hfp, vsw, vbp, hgt, vfp;
   bit  hpol, vpol;

   task automatic check_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic px_t model(int p);
      px_t m;
      int htot = hsw + hbp + wid + hfp;
      int vtot = vsw + vbp + hgt + vfp;
      int h = p % htot;
      int v = (p / htot) % vtot;
      bit ha = (h >= hsw + hbp) && (h < hsw + hbp + wid);
      bit va = (v >= vsw + vbp) && (v < vsw + vbp + hgt);
      m.hs = (h < hsw) ^ hpol;
      m.vs = (v < vsw) ^ vpol;
      m.de = ha && va;
      m.h  = h;
      m.v  = v;
      return m;
   endfunction

   // driver side of the scoreboard
   task automatic push_pixels(int n);
      for (int p = 0; p < n; p++) exp_q.push_back(model(p));
   endtask

   task automatic setup(int a, int b, int c, int d, int e, int f, int g, int k,
                        int dm1, bit den, bit hp, bit vp, bit ien);
      cfg_hsw_m1 = FW'(a);   cfg_hbp_m1 = FW'(b);   cfg_width_m1 = SW'(c);  cfg_hfp_m1 = FW'(d);
      cfg_vsw_m1 = FW'(e);   cfg_vbp_m1 = FW'(f);   cfg_height_m1 = SW'(g); cfg_vfp_m1 = FW'(k);
      cfg_div_m1 = DW'(dm1); cfg_div_en = den; cfg_hs_pol = hp; cfg_vs_pol = vp; irq_en = ien;
      hsw = a + 1; hbp = b + 1; wid = c + 1; hfp = d + 1;
      vsw = e + 1; vbp = f + 1; hgt = g + 1; vfp = k + 1;
      hpol = hp; vpol = vp;
      exp_gap = den ? dm1 + 1 : 1;
   endtask

   task automatic hold_reset();
      @(negedge clk);
      rst_n = 1'b0;
      irq_clr = 1'b0;
      exp_q.delete();
      repeat (2) @(negedge clk);
   endtask

   task automatic release_reset();
      @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic run_ticks(int n);
      int k = 0;
      while (k < n) begin
         @(negedge clk);
         if (pix_ce) k++;
      end
   endtask

   // monitor side of the scoreboard
   int gap = 0;
   bit seen = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         gap = 0;
         seen = 0;
      end else begin
         gap++;
         if (pix_ce) begin
            if (seen) check_eq((exp_gap == 1) ? "R6" : "R7", "pix_ce spacing", gap, exp_gap);
            gap = 0;
            seen = 1;
            if (exp_q.size() > 0) begin
               px_t e;
               e = exp_q.pop_front();
               check_eq("R1", "h_pos", int'(h_pos), e.h);
               check_eq("R2", "v_pos", int'(v_pos), e.v);
               check_eq("R4", "de", int'(de), int'(e.de));
               check_eq("R5", "hsync/vsync", int'({hsync, vsync}), int'({e.hs, e.vs}));
            end
         end
      end
   end

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      // Scenario A: undivided, divider field nonzero, irq enabled; frame = 11 x 7 = 77
      hold_reset();
      setup(1, 2, 3, 1, 0, 1, 2, 0, 5, 1'b0, 1'b0, 1'b0, 1'b1);
      push_pixels(160);
      release_reset();
      @(negedge clk);
      check_eq("R11", "h_pos after reset", int'(h_pos), 0);
      check_eq("R11", "v_pos after reset", int'(v_pos), 0);
      check_eq("R11", "de after reset", int'(de), 0);
      check_eq("R11", "irq_pending after reset", int'(irq_pending), 0);
      run_ticks(76);                                  // showing pixel 76
      check_eq("R8", "irq before first frame wrap", int'(irq_pending), 0);
      @(negedge clk);                                 // pixel 77
      check_eq("R3", "position at frame boundary", int'({h_pos, v_pos}), 0);
      check_eq("R8", "irq at vsync start", int'(irq_pending), 1);
      irq_clr = 1'b1;
      @(negedge clk);                                 // pixel 78
      irq_clr = 1'b0;
      check_eq("R10", "irq after clear", int'(irq_pending), 0);
      run_ticks(75);                                  // pixel 153, last of frame 2
      irq_clr = 1'b1;
      @(negedge clk);                                 // pixel 154
      irq_clr = 1'b0;
      check_eq("R10", "set wins over clear", int'(irq_pending), 1);

      // Scenario B: minimum segments, inverted sync, divisor 3, irq disabled
      hold_reset();
      setup(0, 0, 0, 0, 0, 0, 0, 0, 2, 1'b1, 1'b1, 1'b1, 1'b0);
      push_pixels(33);
      release_reset();
      run_ticks(33);
      check_eq("R9", "irq stays clear when disabled", int'(irq_pending), 0);
      @(negedge clk);
      check_eq("R7", "scoreboard drained", exp_q.size(), 0);

      // Scenario D: divisor 255
      hold_reset();
      setup(1, 2, 3, 1, 0, 1, 2, 0, 254, 1'b1, 1'b0, 1'b0, 1'b0);
      push_pixels(6);
      release_reset();
      run_ticks(6);
      @(negedge clk);
      check_eq("R7", "scoreboard drained at divisor 255", exp_q.size(), 0);

      summary();
      $finish;
   end

endmodule